// File: doc/BRIEF.md
# Translation Miss Refill Walker

This block services a miss in the address translation buffer. When the buffer misses, the walker is given the virtual page number and the physical base address of a single-level page table. It computes where the table entry sits, issues one read through a simple request/response memory port, and waits for the data to come back.

A resident entry has its valid flag set. For such an entry the walker writes the translation (physical page number, reference flag, dirty flag and the remaining status bits) into the buffer and pulses a retry so the faulting access can be replayed. A non-resident entry has its valid flag clear. For such an entry the buffer is left untouched and the walker pulses a page-fault output that carries the faulting virtual page number. Only one walk runs at a time. While a walk is under way a busy output is high and further miss requests are dropped.

Top module: `ptw_engine`

## Requirements
- R1: During and after reset, `busy`, `memReqValid`, `tlbWrEn`, `retryPulse` and `pageFault` are all low.
- R2: The read address is `tableBase + missVpn*4`, computed modulo 2^PA_W, from the values sampled when the miss is accepted.
- R3: `memReqValid` is high in the cycle after a miss is accepted. It stays high, with `memReqAddr` unchanged, until a cycle in which `memReqReady` is high.
- R4: Each walk issues exactly one read. After the request handshake, `memReqValid` stays low and the walker waits for `memRespValid` for any number of cycles, with no timeout.
- R5: If the returned 32-bit entry has bit 31 set, then in the cycle after `memRespValid` the walker holds `tlbWrEn` and `retryPulse` high for exactly one cycle. In that cycle `tlbWrVpn` is the faulting page, `tlbWrPpn` is entry bits 19:0, `tlbWrRef` is bit 20, `tlbWrDirty` is bit 21 and `tlbWrSpare` is bits 30:22.
- R6: If bit 31 of the entry is clear, then in the cycle after `memRespValid` the walker holds `pageFault` high for exactly one cycle, with `faultVpn` equal to the faulting page. `tlbWrEn` and `retryPulse` stay low.
- R7: `busy` is high from the cycle after a miss is accepted through the cycle of the refill or fault pulse, and low in the following cycle.
- R8: A miss presented while `busy` is high is ignored. It does not change the page being walked and it starts no read.
- R9: A miss presented in the first idle cycle after a pulse is accepted, and its request appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Translation miss request |
| missVpn | input | VPN_W | Faulting virtual page number |
| tableBase | input | PA_W | Physical base address of the page table |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | PA_W | Address of the table entry |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 32 | Returned table entry |
| tlbWrEn | output | 1 | One-cycle buffer write strobe |
| tlbWrVpn | output | VPN_W | Virtual page being written |
| tlbWrPpn | output | 20 | Physical page number |
| tlbWrRef | output | 1 | Reference flag |
| tlbWrDirty | output | 1 | Dirty flag |
| tlbWrSpare | output | 9 | Other status bits of the entry |
| retryPulse | output | 1 | Replay the faulting access |
| pageFault | output | 1 | One-cycle page-fault report |
| faultVpn | output | VPN_W | Page that faulted |
| busy | output | 1 | Walk in progress |

## Verification
The bench sweeps every combination of the valid, reference and dirty flags across many page numbers. It varies both the handshake stall and the response latency, and it includes a base and page pair whose sum wraps. An address computed without the four-byte scaling, or without wraparound, shows up as a wrong `memReqAddr`. If the design dropped the request before the handshake or issued a second read, `memReqValid` would be seen at the wrong time. If the design decoded the entry bits wrongly, swapping the reference and dirty flags or refilling on a clear valid bit, the written fields or the fault pulse would not match. Misses injected while a walk is running would expose a walker that re-latches its page or starts a second read, and the back-to-back walks would expose a walker that needs an extra idle cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W   = 32;
  localparam int VALID_BIT = 31;
  localparam int PPN_W     = 20;
  localparam int REF_BIT   = 20;
  localparam int DIRTY_BIT = 21;
  localparam int SPARE_LO  = 22;
  localparam int SPARE_W   = VALID_BIT - SPARE_LO;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_REFILL,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic captureMiss;
    logic captureEntry;
  } dpCtrl_t;
endpackage

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    missValid,
  input  logic    memReqReady,
  input  logic    memRespValid,
  input  logic    entryValid,
  output dpCtrl_t dpCtrl,
  output logic    memReqValid,
  output logic    tlbWrEn,
  output logic    retryPulse,
  output logic    pageFault,
  output logic    busy
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (missValid)    stateNext = ST_REQ;
      ST_REQ:    if (memReqReady)  stateNext = ST_WAIT;
      ST_WAIT:   if (memRespValid) stateNext = entryValid ? ST_REFILL : ST_FAULT;
      ST_REFILL: stateNext = ST_IDLE;
      ST_FAULT:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    dpCtrl.captureMiss  = (state == ST_IDLE) && missValid;
    dpCtrl.captureEntry = (state == ST_WAIT) && memRespValid;
  end

  assign memReqValid = (state == ST_REQ);
  assign tlbWrEn     = (state == ST_REFILL);
  assign retryPulse  = (state == ST_REFILL);
  assign pageFault   = (state == ST_FAULT);
  assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dpCtrl,
  input  logic [VPN_W-1:0]    missVpn,
  input  logic [PA_W-1:0]     tableBase,
  input  logic [ENTRY_W-1:0]  memRespData,
  output logic [PA_W-1:0]     memReqAddr,
  output logic [VPN_W-1:0]    pageVpn,
  output logic [PPN_W-1:0]    entryPpn,
  output logic                entryRef,
  output logic                entryDirty,
  output logic [SPARE_W-1:0]  entrySpare,
  output logic                entryValid
);
  localparam int OFFS_W = VPN_W + 2;

  logic [PA_W-1:0] entryOffset;
  assign entryOffset = PA_W'({missVpn, 2'b00});
  assign entryValid  = memRespData[VALID_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageVpn    <= '0;
      memReqAddr <= '0;
    end else if (dpCtrl.captureMiss) begin
      pageVpn    <= missVpn;
      memReqAddr <= tableBase + entryOffset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryPpn   <= '0;
      entryRef   <= 1'b0;
      entryDirty <= 1'b0;
      entrySpare <= '0;
    end else if (dpCtrl.captureEntry) begin
      entryPpn   <= memRespData[PPN_W-1:0];
      entryRef   <= memRespData[REF_BIT];
      entryDirty <= memRespData[DIRTY_BIT];
      entrySpare <= memRespData[VALID_BIT-1:SPARE_LO];
    end
  end

  if (OFFS_W > PA_W) begin : g_badWidth
    initial $error("PA_W too narrow for scaled page number");
  end
endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
  import ptw_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic [VPN_W-1:0] missVpn,
  input  logic [PA_W-1:0]  tableBase,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRespValid,
  input  logic [31:0]      memRespData,
  output logic             tlbWrEn,
  output logic [VPN_W-1:0] tlbWrVpn,
  output logic [19:0]      tlbWrPpn,
  output logic             tlbWrRef,
  output logic             tlbWrDirty,
  output logic [8:0]       tlbWrSpare,
  output logic             retryPulse,
  output logic             pageFault,
  output logic [VPN_W-1:0] faultVpn,
  output logic             busy
);
  dpCtrl_t          dpCtrl;
  logic             entryValid;
  logic [VPN_W-1:0] pageVpn;

  ptw_control uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .missValid    (missValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .entryValid   (entryValid),
    .dpCtrl       (dpCtrl),
    .memReqValid  (memReqValid),
    .tlbWrEn      (tlbWrEn),
    .retryPulse   (retryPulse),
    .pageFault    (pageFault),
    .busy         (busy)
  );

  ptw_datapath #(.VPN_W(VPN_W), .PA_W(PA_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .dpCtrl      (dpCtrl),
    .missVpn     (missVpn),
    .tableBase   (tableBase),
    .memRespData (memRespData),
    .memReqAddr  (memReqAddr),
    .pageVpn     (pageVpn),
    .entryPpn    (tlbWrPpn),
    .entryRef    (tlbWrRef),
    .entryDirty  (tlbWrDirty),
    .entrySpare  (tlbWrSpare),
    .entryValid  (entryValid)
  );

  assign tlbWrVpn = pageVpn;
  assign faultVpn = pageVpn;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             missValid,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [PA_W-1:0]  memReqAddr,
  input logic             memRespValid,
  input logic             tlbWrEn,
  input logic [VPN_W-1:0] tlbWrVpn,
  input logic             retryPulse,
  input logic             pageFault,
  input logic             busy
);
  // R1
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!busy && !memReqValid && !tlbWrEn && !pageFault));

  // R3
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R4
  p_single_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R5
  p_refill_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    tlbWrEn |=> !tlbWrEn);

  // R5
  p_retry_with_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |-> tlbWrEn);

  // R6
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |=> !pageFault);

  // R6
  p_fault_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    pageFault |-> (!tlbWrEn && !retryPulse));

  // R7
  p_idle_after_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tlbWrEn || pageFault) |=> !busy);

  // R7
  p_busy_covers_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tlbWrEn || pageFault || memReqValid) |-> busy);

  // R8
  p_busy_miss_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && missValid && !tlbWrEn && !pageFault) |=> $stable(tlbWrVpn));

  // R9
  p_accept_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && missValid) |=> memReqValid);
endmodule

bind ptw_engine ptw_checker #(.VPN_W(VPN_W), .PA_W(PA_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .missValid    (missValid),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .tlbWrEn      (tlbWrEn),
  .tlbWrVpn     (tlbWrVpn),
  .retryPulse   (retryPulse),
  .pageFault    (pageFault),
  .busy         (busy)
);

// File: tb/ptw_engine_test.sv
module ptw_engine_test;
  localparam int VPN_W = 20;
  localparam int PA_W  = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             missValid = 1'b0;
  logic [VPN_W-1:0] missVpn = '0;
  logic [PA_W-1:0]  tableBase = '0;
  logic             memReqValid;
  logic             memReqReady = 1'b0;
  logic [PA_W-1:0]  memReqAddr;
  logic             memRespValid = 1'b0;
  logic [31:0]      memRespData = '0;
  logic             tlbWrEn;
  logic [VPN_W-1:0] tlbWrVpn;
  logic [19:0]      tlbWrPpn;
  logic             tlbWrRef;
  logic             tlbWrDirty;
  logic [8:0]       tlbWrSpare;
  logic             retryPulse;
  logic             pageFault;
  logic [VPN_W-1:0] faultVpn;
  logic             busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ptw_engine #(.VPN_W(VPN_W), .PA_W(PA_W)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWalk(input logic [VPN_W-1:0] vpn, input logic [PA_W-1:0] base,
                        input logic [31:0] entry, input int readyLag, input int latency);
    logic [PA_W-1:0] expAddr;
    expAddr = base + PA_W'(vpn) * 4;
    missValid = 1'b1; missVpn = vpn; tableBase = base;
    @(negedge clk);
    missValid = 1'b0; missVpn = ~vpn; tableBase = ~base;
    // R9 / R3: request appears the cycle after acceptance
    check(memReqValid === 1'b1, "R9", 64'(memReqValid), 1);
    check(busy === 1'b1, "R7", 64'(busy), 1);
    check(memReqAddr === expAddr, "R2", 64'(memReqAddr), 64'(expAddr));
    for (int k = 0; k < readyLag; k++) begin
      @(negedge clk);
      check(memReqValid === 1'b1 && memReqAddr === expAddr, "R3",
            64'(memReqAddr), 64'(expAddr));
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    for (int k = 0; k < latency; k++) begin
      // R8: miss while busy, different page
      missValid = 1'b1; missVpn = vpn ^ 20'h1;
      check(memReqValid === 1'b0, "R4", 64'(memReqValid), 0);
      check(!tlbWrEn && !pageFault && busy, "R4", 64'({tlbWrEn, pageFault, busy}), 1);
      @(negedge clk);
    end
    missValid = 1'b0;
    check(memReqValid === 1'b0, "R4", 64'(memReqValid), 0);
    memRespValid = 1'b1; memRespData = entry;
    @(negedge clk);
    memRespValid = 1'b0; memRespData = ~entry;
    check(busy === 1'b1, "R7", 64'(busy), 1);
    if (entry[31]) begin
      check(tlbWrEn === 1'b1 && retryPulse === 1'b1 && pageFault === 1'b0, "R5",
            64'({tlbWrEn, retryPulse, pageFault}), 64'b110);
      check(tlbWrPpn === entry[19:0], "R5", 64'(tlbWrPpn), 64'(entry[19:0]));
      check(tlbWrRef === entry[20] && tlbWrDirty === entry[21], "R5",
            64'({tlbWrDirty, tlbWrRef}), 64'(entry[21:20]));
      check(tlbWrSpare === entry[30:22], "R5", 64'(tlbWrSpare), 64'(entry[30:22]));
      check(tlbWrVpn === vpn, "R8", 64'(tlbWrVpn), 64'(vpn));
    end else begin
      check(pageFault === 1'b1 && tlbWrEn === 1'b0 && retryPulse === 1'b0, "R6",
            64'({pageFault, tlbWrEn, retryPulse}), 64'b100);
      check(faultVpn === vpn, "R6", 64'(faultVpn), 64'(vpn));
    end
    @(negedge clk);
    check(busy === 1'b0, "R7", 64'(busy), 0);
    check(!tlbWrEn && !retryPulse && !pageFault, "R5",
          64'({tlbWrEn, retryPulse, pageFault}), 0);
    check(memReqValid === 1'b0, "R8", 64'(memReqValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !memReqValid && !tlbWrEn && !retryPulse && !pageFault, "R1",
          64'({busy, memReqValid, tlbWrEn, retryPulse, pageFault}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReqValid && !tlbWrEn && !retryPulse && !pageFault, "R1",
          64'({busy, memReqValid, tlbWrEn, retryPulse, pageFault}), 0);
    for (int i = 0; i < 10; i++) begin
      for (int f = 0; f < 8; f++) begin
        logic [VPN_W-1:0] vpn;
        logic [PA_W-1:0]  base;
        logic [31:0]      entry;
        vpn  = (i == 0) ? '0 : (i == 9) ? '1 : VPN_W'(i * 32'h24925 + f * 7);
        base = (i == 9) ? 32'hFFFF_F000 : 32'h8000_0000 + 32'(i) * 32'h0001_0000;
        entry = {f[2], 9'(i * 37 + f), f[1], f[0], 20'(vpn ^ 20'hA5A5A ^ 20'(f))};
        doWalk(vpn, base, entry, (i + f) % 3, (i * 3 + f) % 5);
      end
    end
    // R4: long response wait with no timeout
    doWalk(20'h00ABC, 32'h1000_0000, 32'h8012_3456, 0, 40);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule